// File: doc/BRIEF.md
# LCD Scanline Timing and Status Generator

This block turns a single pixel-domain clock into the line and frame timing of a 240x160 panel. Every line is a draw phase followed by a shorter blank phase. The first 160 lines are visible and the remaining 68 lines form vertical blank. The block keeps the current line number and the horizontal-blank, vertical-blank and line-match flags. It emits single-cycle interrupt pulses, DMA trigger pulses and a render strobe that tells a pixel pipeline when a visible line begins. It also holds the two affine background reference points. Each point steps by a per-line increment on every visible line and is reloaded from its programmed base when vertical blank starts.

The control is a four-state sequencer, with states `PH_DRAW`, `PH_HBLANK`, `PH_VDRAW` and `PH_VHBLANK`. It has these transitions:
- `T_DRAW_END`: `PH_DRAW` to `PH_HBLANK`.
- `T_NEXT_VIS`: `PH_HBLANK` to `PH_DRAW`, taken when the next line is still visible.
- `T_ENTER_VBL`: `PH_HBLANK` to `PH_VDRAW`, taken when the next line is the first blank line.
- `T_VDRAW_END`: `PH_VDRAW` to `PH_VHBLANK`.
- `T_NEXT_VBL`: `PH_VHBLANK` to `PH_VDRAW`.
- `T_WRAP`: `PH_VHBLANK` to `PH_DRAW`, taken on the last line, where the line counter returns to 0.

A cycle counter runs inside each state. It ends a draw-type state after `DRAW_CYC` cycles and a blank-type state after `BLANK_CYC` cycles.

Top module: `lcd_scan_timing`

## Requirements
- R1: After reset the block is in line 0, draw phase, with all `status` bits 0. Each line is `DRAW_CYC` (default 1006) cycles of draw followed by `BLANK_CYC` (default 226) cycles of blank. `status[0]` (h-blank) is 1 exactly during the blank phase of every line, vertical-blank lines included.
- R2: `line_no` advances by one in the first cycle after each blank phase ends. It counts 0 to `VIS_LINES+VBL_LINES-1` (default 227) and then wraps to 0, so a frame lasts 280896 cycles by default.
- R3: `status[1]` (v-blank) is 1 exactly while `line_no` is at or above `VIS_LINES` (default 160).
- R4: In the first cycle of every blank phase, `irq_hblank` pulses for one cycle when `hblank_irq_en` is 1, on every line. In that same cycle `dma_hblank` pulses, but only on visible lines, and it does not depend on any enable.
- R5: In the first cycle of line `VIS_LINES`, `dma_vblank` pulses for one cycle. `irq_vblank` pulses in the same cycle when `vblank_irq_en` is 1.
- R6: `status[2]` (line match) is 0 after reset. At each line change it takes the value (new line == `match_line`) and holds that value until the next change. A change of `match_line` in the middle of a line has no effect before the next line change. When the new value is 1 and `match_irq_en` is 1, `irq_match` pulses in the first cycle of the new line.
- R7: `render_start` pulses for one cycle in the first cycle of each visible line reached by a line advance. This covers lines 1 to `VIS_LINES-1` and line 0 after a wrap, but not line 0 straight after reset.
- R8: On each advance into visible lines 1 to `VIS_LINES-1`, each reference point adds its sign-extended 16-bit increment to its X and its Y. The result wraps modulo 2^`COORD_W`. No other advance steps the points.
- R9: On the advance into line `VIS_LINES`, each reference point's X and Y reload from `aff_base_x`/`aff_base_y`. In cycles with neither a step nor a reload the reference points hold. They are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hblank_irq_en | input | 1 | Enables the h-blank interrupt pulse |
| vblank_irq_en | input | 1 | Enables the v-blank interrupt pulse |
| match_irq_en | input | 1 | Enables the line-match interrupt pulse |
| match_line | input | LINE_W | Programmed line number to compare against |
| aff_base_x | input | NUM_AFF x COORD_W | Base X per reference point |
| aff_base_y | input | NUM_AFF x COORD_W | Base Y per reference point |
| aff_inc_x | input | NUM_AFF x INC_W | Signed per-line X increment per point |
| aff_inc_y | input | NUM_AFF x INC_W | Signed per-line Y increment per point |
| line_no | output | LINE_W | Current line number |
| status | output | 3 | {match, v-blank, h-blank} flags |
| irq_hblank | output | 1 | H-blank interrupt pulse |
| irq_vblank | output | 1 | V-blank interrupt pulse |
| irq_match | output | 1 | Line-match interrupt pulse |
| dma_hblank | output | 1 | H-blank DMA trigger pulse (visible lines only) |
| dma_vblank | output | 1 | V-blank DMA trigger pulse |
| render_start | output | 1 | Start-of-visible-line strobe |
| aff_ref_x | output | NUM_AFF x COORD_W | Current internal X per reference point |
| aff_ref_y | output | NUM_AFF x COORD_W | Current internal Y per reference point |

## Verification
Two collisions matter most:
- When `match_line` equals the first blank line, the line-match flag, its interrupt, the v-blank interrupt, the v-blank DMA trigger and the reference-point reload all fall on the same cycle.
- When `match_line` is 0, the match fires on the wrap together with the render strobe.

The bench provokes both by programming those two values in separate runs over several shortened frames. In every cycle it compares all outputs with values it derives from the cycle number's position within the line and the frame. A run with every enable low shows that the flags still move while no interrupt pulse appears. Another run moves `match_line` in the middle of a line and checks that the flag waits for the next line change.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

    typedef enum logic [1:0] {
        PH_DRAW    = 2'd0,
        PH_HBLANK  = 2'd1,
        PH_VDRAW   = 2'd2,
        PH_VHBLANK = 2'd3
    } phase_e;

    localparam int ST_HBL   = 0;
    localparam int ST_VBL   = 1;
    localparam int ST_MATCH = 2;

endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_timing_pkg::*;
#(
    parameter int DRAW_CYC  = 1006,
    parameter int BLANK_CYC = 226,
    parameter int VIS_LINES = 160,
    parameter int VBL_LINES = 68,
    localparam int TOTAL    = VIS_LINES + VBL_LINES,
    localparam int LINE_W   = $clog2(TOTAL),
    localparam int MAX_DUR  = (DRAW_CYC > BLANK_CYC) ? DRAW_CYC : BLANK_CYC,
    localparam int CNT_W    = $clog2(MAX_DUR)
) (
    input  logic              clk,
    input  logic              rst_n,
    output phase_e            phase,
    output logic [LINE_W-1:0] line,
    output logic [LINE_W-1:0] nxt_line,
    output logic              draw_end,
    output logic              line_adv
);

    logic [CNT_W-1:0] cnt, nxt_cnt;
    phase_e           nxt_phase;
    logic             last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_DRAW;
            cnt   <= '0;
            line  <= '0;
        end else begin
            phase <= nxt_phase;
            cnt   <= nxt_cnt;
            line  <= nxt_line;
        end
    end

    assign last = (phase == PH_DRAW || phase == PH_VDRAW)
                ? (cnt == CNT_W'(DRAW_CYC - 1))
                : (cnt == CNT_W'(BLANK_CYC - 1));

    // transitions and event outputs
    always_comb begin
        nxt_phase = phase;
        nxt_cnt   = cnt + 1'b1;
        nxt_line  = line;
        draw_end  = 1'b0;
        line_adv  = 1'b0;
        unique case (phase)
            PH_DRAW: if (last) begin            // T_DRAW_END
                nxt_phase = PH_HBLANK;
                nxt_cnt   = '0;
                draw_end  = 1'b1;
            end
            PH_HBLANK: if (last) begin
                nxt_cnt  = '0;
                line_adv = 1'b1;
                nxt_line = line + 1'b1;
                nxt_phase = (line == LINE_W'(VIS_LINES - 1))
                          ? PH_VDRAW            // T_ENTER_VBL
                          : PH_DRAW;            // T_NEXT_VIS
            end
            PH_VDRAW: if (last) begin           // T_VDRAW_END
                nxt_phase = PH_VHBLANK;
                nxt_cnt   = '0;
                draw_end  = 1'b1;
            end
            PH_VHBLANK: if (last) begin
                nxt_cnt  = '0;
                line_adv = 1'b1;
                if (line == LINE_W'(TOTAL - 1)) begin
                    nxt_line  = '0;             // T_WRAP
                    nxt_phase = PH_DRAW;
                end else begin
                    nxt_line  = line + 1'b1;    // T_NEXT_VBL
                    nxt_phase = PH_VDRAW;
                end
            end
        endcase
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(MAX_DUR)); // R1
    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line < LINE_W'(TOTAL)); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv && line == LINE_W'(TOTAL - 1)) |=> (line == '0)); // R2
    AST_PHASE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_DRAW || phase == PH_HBLANK) == (line < LINE_W'(VIS_LINES)))); // R3

endmodule

// File: rtl/lcd_event_gen.sv
module lcd_event_gen #(
    parameter int VIS_LINES = 160,
    parameter int LINE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              draw_end,
    input  logic              line_adv,
    input  logic              in_visible,
    input  logic [LINE_W-1:0] nxt_line,
    input  logic [LINE_W-1:0] match_line,
    input  logic              hblank_irq_en,
    input  logic              vblank_irq_en,
    input  logic              match_irq_en,
    output logic              match_flag,
    output logic              irq_hblank,
    output logic              irq_vblank,
    output logic              irq_match,
    output logic              dma_hblank,
    output logic              dma_vblank,
    output logic              render_start,
    output logic              aff_step,
    output logic              aff_reload
);

    logic vbl_enter, hit, vis_next;

    assign vbl_enter  = line_adv && (nxt_line == LINE_W'(VIS_LINES));
    assign hit        = (nxt_line == match_line);
    assign vis_next   = nxt_line < LINE_W'(VIS_LINES);
    assign aff_step   = line_adv && vis_next && (nxt_line != '0);
    assign aff_reload = vbl_enter;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_flag   <= 1'b0;
            irq_hblank   <= 1'b0;
            irq_vblank   <= 1'b0;
            irq_match    <= 1'b0;
            dma_hblank   <= 1'b0;
            dma_vblank   <= 1'b0;
            render_start <= 1'b0;
        end else begin
            irq_hblank   <= draw_end && hblank_irq_en;
            dma_hblank   <= draw_end && in_visible;
            irq_vblank   <= vbl_enter && vblank_irq_en;
            dma_vblank   <= vbl_enter;
            irq_match    <= line_adv && hit && match_irq_en;
            render_start <= line_adv && vis_next;
            if (line_adv) match_flag <= hit;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hblank |=> !irq_hblank); // R4
    AST_MATCH_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match |-> match_flag); // R6
    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_adv |=> $stable(match_flag)); // R6

endmodule

// File: rtl/lcd_affine_acc.sv
module lcd_affine_acc #(
    parameter int COORD_W = 28,
    parameter int INC_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               reload,
    input  logic [COORD_W-1:0] base_x,
    input  logic [COORD_W-1:0] base_y,
    input  logic [INC_W-1:0]   inc_x,
    input  logic [INC_W-1:0]   inc_y,
    output logic [COORD_W-1:0] ref_x,
    output logic [COORD_W-1:0] ref_y
);

    localparam int EXT_W = COORD_W - INC_W;

    logic [COORD_W-1:0] sx, sy;
    assign sx = {{EXT_W{inc_x[INC_W-1]}}, inc_x};
    assign sy = {{EXT_W{inc_y[INC_W-1]}}, inc_y};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_x <= '0;
            ref_y <= '0;
        end else if (reload) begin
            ref_x <= base_x;
            ref_y <= base_y;
        end else if (step) begin
            ref_x <= ref_x + sx;
            ref_y <= ref_y + sy;
        end
    end

    AST_AFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !reload) |=> ($stable(ref_x) && $stable(ref_y))); // R9
    AST_AFF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (ref_x == $past(base_x) && ref_y == $past(base_y))); // R9

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
    import lcd_timing_pkg::*;
#(
    parameter int DRAW_CYC  = 1006,
    parameter int BLANK_CYC = 226,
    parameter int VIS_LINES = 160,
    parameter int VBL_LINES = 68,
    parameter int NUM_AFF   = 2,
    parameter int COORD_W   = 28,
    parameter int INC_W     = 16,
    localparam int LINE_W   = $clog2(VIS_LINES + VBL_LINES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            hblank_irq_en,
    input  logic                            vblank_irq_en,
    input  logic                            match_irq_en,
    input  logic [LINE_W-1:0]               match_line,
    input  logic [NUM_AFF-1:0][COORD_W-1:0] aff_base_x,
    input  logic [NUM_AFF-1:0][COORD_W-1:0] aff_base_y,
    input  logic [NUM_AFF-1:0][INC_W-1:0]   aff_inc_x,
    input  logic [NUM_AFF-1:0][INC_W-1:0]   aff_inc_y,
    output logic [LINE_W-1:0]               line_no,
    output logic [2:0]                      status,
    output logic                            irq_hblank,
    output logic                            irq_vblank,
    output logic                            irq_match,
    output logic                            dma_hblank,
    output logic                            dma_vblank,
    output logic                            render_start,
    output logic [NUM_AFF-1:0][COORD_W-1:0] aff_ref_x,
    output logic [NUM_AFF-1:0][COORD_W-1:0] aff_ref_y
);

    phase_e            phase;
    logic [LINE_W-1:0] nxt_line;
    logic              draw_end, line_adv, match_flag, aff_step, aff_reload;

    lcd_phase_seq #(
        .DRAW_CYC (DRAW_CYC),
        .BLANK_CYC(BLANK_CYC),
        .VIS_LINES(VIS_LINES),
        .VBL_LINES(VBL_LINES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .line    (line_no),
        .nxt_line(nxt_line),
        .draw_end(draw_end),
        .line_adv(line_adv)
    );

    lcd_event_gen #(
        .VIS_LINES(VIS_LINES),
        .LINE_W   (LINE_W)
    ) u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .draw_end     (draw_end),
        .line_adv     (line_adv),
        .in_visible   (phase == PH_DRAW),
        .nxt_line     (nxt_line),
        .match_line   (match_line),
        .hblank_irq_en(hblank_irq_en),
        .vblank_irq_en(vblank_irq_en),
        .match_irq_en (match_irq_en),
        .match_flag   (match_flag),
        .irq_hblank   (irq_hblank),
        .irq_vblank   (irq_vblank),
        .irq_match    (irq_match),
        .dma_hblank   (dma_hblank),
        .dma_vblank   (dma_vblank),
        .render_start (render_start),
        .aff_step     (aff_step),
        .aff_reload   (aff_reload)
    );

    generate
        for (genvar i = 0; i < NUM_AFF; i++) begin : g_aff
            lcd_affine_acc #(
                .COORD_W(COORD_W),
                .INC_W  (INC_W)
            ) u_acc (
                .clk   (clk),
                .rst_n (rst_n),
                .step  (aff_step),
                .reload(aff_reload),
                .base_x(aff_base_x[i]),
                .base_y(aff_base_y[i]),
                .inc_x (aff_inc_x[i]),
                .inc_y (aff_inc_y[i]),
                .ref_x (aff_ref_x[i]),
                .ref_y (aff_ref_y[i])
            );
        end
    endgenerate

    always_comb begin
        status           = '0;
        status[ST_HBL]   = (phase == PH_HBLANK) || (phase == PH_VHBLANK);
        status[ST_VBL]   = (phase == PH_VDRAW)  || (phase == PH_VHBLANK);
        status[ST_MATCH] = match_flag;
    end

    AST_HDMA_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_hblank |-> (status[ST_HBL] && !status[ST_VBL])); // R4
    AST_VBL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_vblank |-> $rose(status[ST_VBL])); // R5
    AST_RENDER_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
        render_start |-> (!status[ST_HBL] && !status[ST_VBL])); // R7

endmodule

// File: tb/tb_lcd_scan_timing.sv
module tb_lcd_scan_timing;

    localparam int DRAW  = 6;
    localparam int BLANK = 4;
    localparam int VIS   = 4;
    localparam int VBL   = 3;
    localparam int TOT   = VIS + VBL;
    localparam int LW    = $clog2(TOT);
    localparam int LINE  = DRAW + BLANK;
    localparam int FRAME = LINE * TOT;
    localparam int CW    = 28;
    localparam int IW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_h, en_v, en_m;
    logic [LW-1:0] match_line;
    logic [1:0][CW-1:0] base_x, base_y, ref_x, ref_y;
    logic [1:0][IW-1:0] inc_x, inc_y;
    logic [LW-1:0] line_no;
    logic [2:0] status;
    logic irq_h, irq_v, irq_m, dma_h, dma_v, rstart;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    lcd_scan_timing #(
        .DRAW_CYC(DRAW), .BLANK_CYC(BLANK), .VIS_LINES(VIS), .VBL_LINES(VBL),
        .NUM_AFF(2), .COORD_W(CW), .INC_W(IW)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .hblank_irq_en(en_h), .vblank_irq_en(en_v), .match_irq_en(en_m),
        .match_line(match_line),
        .aff_base_x(base_x), .aff_base_y(base_y),
        .aff_inc_x(inc_x), .aff_inc_y(inc_y),
        .line_no(line_no), .status(status),
        .irq_hblank(irq_h), .irq_vblank(irq_v), .irq_match(irq_m),
        .dma_hblank(dma_h), .dma_vblank(dma_v), .render_start(rstart),
        .aff_ref_x(ref_x), .aff_ref_y(ref_y)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp, input int t);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s t=%0d actual=%0h expected=%0h", req, what, t, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] aff_exp(input logic [CW-1:0] base,
                                              input logic [IW-1:0] inc,
                                              input int f, input int l);
        longint s, r;
        if (l >= VIS) return base;
        s = (f == 0) ? 0 : longint'(base);
        r = s + longint'(l) * longint'($signed(inc));
        return r[CW-1:0];
    endfunction

    // one scenario: reset, then compare every output in every cycle
    task automatic run(input int ncyc, input int chg_t, input logic [LW-1:0] chg_val);
        int t;
        bit mflag;
        logic [LW-1:0] mv;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t = 0;
        mflag = 0;
        mv = match_line;
        for (int k = 0; k < ncyc; k++) begin
            int p, l, f;
            bit ls;
            p  = t % LINE;
            l  = (t / LINE) % TOT;
            f  = t / FRAME;
            ls = (p == 0) && (t > 0);
            if (ls) mflag = (l == int'(mv));
            // R1 reset state and h-blank flag timing; R2 line counter
            chk(status[0] == (p >= DRAW), "R1", "hblank", status[0], p >= DRAW, t);
            chk(line_no == LW'(l), "R2", "line", line_no, l, t);
            chk(status[1] == (l >= VIS), "R3", "vblank", status[1], l >= VIS, t);
            chk(irq_h == (en_h && p == DRAW), "R4", "irq_hblank", irq_h, en_h && p == DRAW, t);
            chk(dma_h == (p == DRAW && l < VIS), "R4", "dma_hblank", dma_h, p == DRAW && l < VIS, t);
            chk(dma_v == (ls && l == VIS), "R5", "dma_vblank", dma_v, ls && l == VIS, t);
            chk(irq_v == (en_v && ls && l == VIS), "R5", "irq_vblank", irq_v, en_v && ls && l == VIS, t);
            chk(status[2] == mflag, "R6", "match_flag", status[2], mflag, t);
            chk(irq_m == (en_m && ls && l == int'(mv)), "R6", "irq_match", irq_m,
                en_m && ls && l == int'(mv), t);
            chk(rstart == (ls && l < VIS), "R7", "render_start", rstart, ls && l < VIS, t);
            for (int i = 0; i < 2; i++) begin
                logic [CW-1:0] ex, ey;
                ex = aff_exp(base_x[i], inc_x[i], f, l);
                ey = aff_exp(base_y[i], inc_y[i], f, l);
                // R8 per-line step, R9 reload at v-blank entry and hold
                chk(ref_x[i] == ex, (l >= VIS) ? "R9" : "R8", "ref_x", ref_x[i], ex, t);
                chk(ref_y[i] == ey, (l >= VIS) ? "R9" : "R8", "ref_y", ref_y[i], ey, t);
            end
            if (t == chg_t) match_line = chg_val;
            mv = match_line;
            @(posedge clk);
            t++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        en_h = 1; en_v = 1; en_m = 1;
        match_line = 3'd2;
        base_x[0] = 28'd100;       base_y[0] = -28'sd50;
        base_x[1] = 28'h0ABCDEF;   base_y[1] = 28'd7;
        inc_x[0]  = 16'd3;         inc_y[0]  = 16'hFFFE;
        inc_x[1]  = 16'h8000;      inc_y[1]  = 16'h7FFF;
        // mid-line move of the match line (R6)
        run(3 * FRAME + 5, LINE + 3, 3'd1);

        // match on the first v-blank line: collides with v-blank events
        match_line = LW'(VIS);
        inc_x[0] = 16'hFFFF; inc_y[1] = 16'h0001;
        base_x[0] = 28'hFFFFFF0;
        run(3 * FRAME + 5, -1, '0);

        // all enables low, match on line 0 (wrap with render strobe)
        en_h = 0; en_v = 0; en_m = 0;
        match_line = 3'd0;
        run(3 * FRAME + 5, -1, '0);

        // match on the last line of the frame
        en_h = 1; en_v = 0; en_m = 1;
        match_line = LW'(TOT - 1);
        inc_x[1] = 16'h1234; inc_y[0] = 16'h8001;
        run(3 * FRAME + 5, -1, '0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule